// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of an Ethernet DMA. Software fills a small internal table of receive descriptors. Each descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer address. Software then points the engine at the first slot of its ring and kicks it with a poll command. Frames arrive as a byte stream. The framing and CRC logic upstream mark the last byte and report error flags on that last byte.

For each frame, the engine claims the current descriptor if software has left it empty. It writes the frame bytes through a byte-write port starting at the descriptor's buffer address. On the last byte it records the byte count, which includes the CRC. It also records the error flags and a truncation flag, hands the descriptor back by clearing its empty bit, and moves on. A descriptor with its wrap bit set sends the engine back to the ring's first slot. If a frame finds no free descriptor, the frame is discarded and counted. The engine then stays idle until the next poll command. It also parks itself when closing a frame leaves it facing a descriptor that software has not yet refilled.

Status word layout (software visible): bit 15 = empty (engine owns the descriptor), bit 13 = wrap, bit 5 = over-length truncation, bits 4:0 = receive error flags copied from the stream. All other bits are kept as software wrote them.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset `rxActive` is 0, `overrunCnt` is 0, `ringIdx` is 0, `memWrEn` is 0 and every descriptor field reads 0.
- R2: While `enable` is 1, a poll write whose data is exactly 0x01000000 sets `rxActive`, one cycle later, to bit 15 of the current descriptor's status. A poll write with any other data leaves `rxActive` unchanged.
- R3: Each accepted byte of a frame drives `memWrEn` high in the same cycle it is presented. `memWrAddr` is the descriptor's buffer address plus the byte's offset in the frame, and `memWrData` is the byte itself.
- R4: One cycle after the last byte, the descriptor's status has bit 15 cleared, bits 4:0 equal to `inErr` sampled with the last byte, bit 5 equal to the truncation flag, and all other bits unchanged. Its length equals the number of bytes stored, CRC included.
- R5: A frame carrying nonzero error flags is still stored, closed and handed back like a clean one.
- R6: On close, the ring index moves to the ring base if the closed descriptor's wrap bit (13) is set. Otherwise it moves to the next index, rolling from the last table slot to 0.
- R7: A frame that starts while `rxActive` is 0, or while the current descriptor is not empty, causes no memory write and leaves the descriptor unchanged. It increments `overrunCnt` by one and leaves `rxActive` at 0.
- R8: After a close, `rxActive` stays 1 if the next descriptor is empty and drops to 0 if it is not.
- R9: Bytes past 1520 (the buffer limit) are not written. The length field records 1520 and status bit 5 is set.
- R10: While `enable` is 0, `rxActive` is 0 and a base write loads both the ring base and `ringIdx`. While `enable` is 1, base writes are ignored.
- R11: Software writes descriptor fields through the write port, with select 0 for status, 1 for length and 2 for address. It reads all three fields of any slot through the combinational read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable |
| baseWrEn | input | 1 | Ring base write strobe |
| baseWrIdx | input | IDX_W | Ring base slot index |
| pollWrEn | input | 1 | Poll command write strobe |
| pollWrData | input | 32 | Poll command value |
| descWrEn | input | 1 | Descriptor field write strobe |
| descWrIdx | input | IDX_W | Descriptor slot to write |
| descWrSel | input | 2 | Field select: 0 status, 1 length, 2 address |
| descWrData | input | 32 | Field write data |
| descRdIdx | input | IDX_W | Descriptor slot to read |
| descRdStatus | output | 16 | Status of the read slot |
| descRdLen | output | 16 | Length of the read slot |
| descRdAddr | output | 32 | Buffer address of the read slot |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Last byte of frame |
| inErr | input | 5 | Receive error flags, valid with last byte |
| memWrEn | output | 1 | Buffer byte write strobe |
| memWrAddr | output | 32 | Buffer byte address |
| memWrData | output | 8 | Buffer byte data |
| rxActive | output | 1 | Engine is accepting frames |
| ringIdx | output | IDX_W | Current descriptor index |
| overrunCnt | output | CNT_W | Frames dropped for lack of a descriptor |

## Verification
The hardest state to reach is the ring-full stall. The engine must wrap through its last descriptor and then find the base slot still closed from the first lap. The vector loop drives a four-slot ring placed mid-table, with the wrap bit on the fourth slot, and feeds exactly four frames, so the final close lands on the full condition. A further frame then arrives while the engine is parked, to show the drop counter and the unchanged descriptor. A separate directed case makes software reclaim a descriptor after a poll has already activated the engine, which reaches the "active but not empty" drop path.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int EMPTY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int TRUNC_BIT = 5;
  localparam int ERR_W     = 5;
  localparam logic [31:0] POLL_CMD = 32'h0100_0000;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_LEN    = 2'd1;
  localparam logic [1:0] SEL_ADDR   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DROP  = 2'd2,
    ST_CLOSE = 2'd3
  } rx_state_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic acceptByte;
    logic closeFrame;
    logic countDrop;
  } rx_strobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        pollWrEn,
  input  logic [31:0] pollWrData,
  input  logic        curEmpty,
  input  logic        nextEmpty,
  output rx_strobe_t  strb,
  output logic        rxActive
);
  rx_state_t state, nextState;
  logic pollHit;

  assign pollHit = enable && pollWrEn && (pollWrData == POLL_CMD);

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (enable && inValid) begin
          if (rxActive && curEmpty) begin
            strb.acceptByte = 1'b1;
            nextState       = inLast ? ST_CLOSE : ST_RECV;
          end else begin
            strb.countDrop = 1'b1;
            nextState      = inLast ? ST_IDLE : ST_DROP;
          end
        end
      end
      ST_RECV: begin
        if (inValid) begin
          strb.acceptByte = 1'b1;
          if (inLast) nextState = ST_CLOSE;
        end
      end
      ST_DROP: begin
        if (inValid && inLast) nextState = ST_IDLE;
      end
      ST_CLOSE: begin
        strb.closeFrame = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rxActive <= 1'b0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      rxActive <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.closeFrame)     rxActive <= nextEmpty;
      else if (strb.countDrop) rxActive <= 1'b0;
      else if (pollHit)        rxActive <= curEmpty;
    end
  end

  // R2
  poll_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollHit && !strb.closeFrame && !strb.countDrop |=> rxActive == $past(curEmpty));

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !rxActive);

  // R8
  ring_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && strb.closeFrame && !nextEmpty |=> !rxActive);

  // R7
  drop_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.countDrop |=> !rxActive);
endmodule

// File: rtl/rx_ring_dpath.sv
module rx_ring_dpath
  import rx_ring_pkg::*;
#(
  parameter int NDESC     = 8,
  parameter int BUF_LIMIT = 1520,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int BC_W     = $clog2(BUF_LIMIT + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  rx_strobe_t       strb,
  input  logic             baseWrEn,
  input  logic [IDX_W-1:0] baseWrIdx,
  input  logic             descWrEn,
  input  logic [IDX_W-1:0] descWrIdx,
  input  logic [1:0]       descWrSel,
  input  logic [31:0]      descWrData,
  input  logic [IDX_W-1:0] descRdIdx,
  output logic [15:0]      descRdStatus,
  output logic [15:0]      descRdLen,
  output logic [31:0]      descRdAddr,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic [ERR_W-1:0] inErr,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [7:0]       memWrData,
  output logic             curEmpty,
  output logic             nextEmpty,
  output logic [IDX_W-1:0] ringIdx,
  output logic [CNT_W-1:0] overrunCnt
);
  logic [15:0] descStatus [NDESC];
  logic [15:0] descLen    [NDESC];
  logic [31:0] descAddr   [NDESC];

  logic [IDX_W-1:0] curIdx, baseIdx, nextIdx;
  logic [BC_W-1:0]  byteCnt;
  logic             truncFlag;
  logic [ERR_W-1:0] errReg;
  logic             room;
  logic [15:0]      closedStatus;

  assign ringIdx  = curIdx;
  assign room     = byteCnt < BC_W'(BUF_LIMIT);
  assign curEmpty = descStatus[curIdx][EMPTY_BIT];

  always_comb begin
    if (descStatus[curIdx][WRAP_BIT])          nextIdx = baseIdx;
    else if (curIdx == IDX_W'(NDESC - 1))      nextIdx = '0;
    else                                       nextIdx = curIdx + 1'b1;
  end

  // a one-slot ring points back at the slot being closed, which is never empty
  assign nextEmpty = (nextIdx == curIdx) ? 1'b0 : descStatus[nextIdx][EMPTY_BIT];

  always_comb begin
    closedStatus = descStatus[curIdx];
    closedStatus[EMPTY_BIT] = 1'b0;
    closedStatus[TRUNC_BIT] = truncFlag;
    closedStatus[ERR_W-1:0] = errReg;
  end

  assign memWrEn   = strb.acceptByte && room;
  assign memWrAddr = descAddr[curIdx] + 32'(byteCnt);
  assign memWrData = inData;

  assign descRdStatus = descStatus[descRdIdx];
  assign descRdLen    = descLen[descRdIdx];
  assign descRdAddr   = descAddr[descRdIdx];

  // frame bookkeeping and ring position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx     <= '0;
      baseIdx    <= '0;
      byteCnt    <= '0;
      truncFlag  <= 1'b0;
      errReg     <= '0;
      overrunCnt <= '0;
    end else begin
      if (!enable && baseWrEn) begin
        baseIdx <= baseWrIdx;
        curIdx  <= baseWrIdx;
      end
      if (!enable) begin
        byteCnt   <= '0;
        truncFlag <= 1'b0;
      end else if (strb.closeFrame) begin
        curIdx    <= nextIdx;
        byteCnt   <= '0;
        truncFlag <= 1'b0;
      end else if (strb.acceptByte) begin
        if (room) byteCnt   <= byteCnt + 1'b1;
        else      truncFlag <= 1'b1;
        if (inLast) errReg <= inErr;
      end
      if (strb.countDrop) overrunCnt <= overrunCnt + 1'b1;
    end
  end

  // descriptor table: software port, engine close has priority on its slot
  generate
    for (genvar gi = 0; gi < NDESC; gi++) begin : g_slot
      logic engineHit, swHit;
      assign engineHit = strb.closeFrame && (curIdx == IDX_W'(gi));
      assign swHit     = descWrEn && (descWrIdx == IDX_W'(gi)) && !engineHit;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          descStatus[gi] <= '0;
          descLen[gi]    <= '0;
          descAddr[gi]   <= '0;
        end else if (engineHit) begin
          descStatus[gi] <= closedStatus;
          descLen[gi]    <= 16'(byteCnt);
        end else if (swHit) begin
          unique case (descWrSel)
            SEL_STATUS: descStatus[gi] <= descWrData[15:0];
            SEL_LEN:    descLen[gi]    <= descWrData[15:0];
            SEL_ADDR:   descAddr[gi]   <= descWrData;
            default: ;
          endcase
        end
      end
    end
  endgenerate

  // R7
  drop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.countDrop |=> overrunCnt == $past(overrunCnt) + 1'b1);

  // R9
  trunc_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && strb.acceptByte && !strb.closeFrame && byteCnt == BC_W'(BUF_LIMIT) |=> truncFlag);

  // R4
  close_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeFrame && enable |=> !descStatus[$past(curIdx)][EMPTY_BIT]);

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && strb.closeFrame && !descStatus[curIdx][WRAP_BIT] && curIdx != IDX_W'(NDESC - 1)
    |=> curIdx == $past(curIdx) + 1'b1);

  // R3
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> strb.acceptByte && byteCnt < BC_W'(BUF_LIMIT));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rx_ring_pkg::*;
#(
  parameter int NDESC     = 8,
  parameter int BUF_LIMIT = 1520,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NDESC > 1) ? $clog2(NDESC) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             baseWrEn,
  input  logic [IDX_W-1:0] baseWrIdx,
  input  logic             pollWrEn,
  input  logic [31:0]      pollWrData,
  input  logic             descWrEn,
  input  logic [IDX_W-1:0] descWrIdx,
  input  logic [1:0]       descWrSel,
  input  logic [31:0]      descWrData,
  input  logic [IDX_W-1:0] descRdIdx,
  output logic [15:0]      descRdStatus,
  output logic [15:0]      descRdLen,
  output logic [31:0]      descRdAddr,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic [4:0]       inErr,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [7:0]       memWrData,
  output logic             rxActive,
  output logic [IDX_W-1:0] ringIdx,
  output logic [CNT_W-1:0] overrunCnt
);
  rx_strobe_t strb;
  logic curEmpty, nextEmpty;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .inValid(inValid), .inLast(inLast),
    .pollWrEn(pollWrEn), .pollWrData(pollWrData),
    .curEmpty(curEmpty), .nextEmpty(nextEmpty),
    .strb(strb), .rxActive(rxActive)
  );

  rx_ring_dpath #(.NDESC(NDESC), .BUF_LIMIT(BUF_LIMIT), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
    .baseWrEn(baseWrEn), .baseWrIdx(baseWrIdx),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWrSel(descWrSel), .descWrData(descWrData),
    .descRdIdx(descRdIdx), .descRdStatus(descRdStatus), .descRdLen(descRdLen), .descRdAddr(descRdAddr),
    .inData(inData), .inLast(inLast), .inErr(inErr),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .curEmpty(curEmpty), .nextEmpty(nextEmpty),
    .ringIdx(ringIdx), .overrunCnt(overrunCnt)
  );
endmodule

// File: tb/tb_rx_desc_ring.sv
module tb_rx_desc_ring;
  localparam int IDX_W = 3;
  localparam int LIMIT = 1520;

  logic clk = 0, rstN = 0, enable = 0;
  logic baseWrEn = 0; logic [IDX_W-1:0] baseWrIdx = '0;
  logic pollWrEn = 0; logic [31:0] pollWrData = '0;
  logic descWrEn = 0; logic [IDX_W-1:0] descWrIdx = '0;
  logic [1:0] descWrSel = '0; logic [31:0] descWrData = '0;
  logic [IDX_W-1:0] descRdIdx = '0;
  logic [15:0] descRdStatus, descRdLen; logic [31:0] descRdAddr;
  logic inValid = 0, inLast = 0; logic [7:0] inData = '0; logic [4:0] inErr = '0;
  logic memWrEn; logic [31:0] memWrAddr; logic [7:0] memWrData;
  logic rxActive; logic [IDX_W-1:0] ringIdx; logic [15:0] overrunCnt;

  int checks = 0, failures = 0, wrSeen, wrBad;
  bit done = 0;

  always #4 clk = ~clk;

  rx_desc_ring dut (.*);

  typedef struct packed {
    logic [15:0] len; logic [4:0] err; logic [2:0] idx; logic act; logic [15:0] stat;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{16'd64,   5'h00, 3'd3, 1'b1, 16'h0000},
    '{16'd100,  5'h03, 3'd4, 1'b1, 16'h0003},   // R5 errored frame still closes
    '{16'd70,   5'h00, 3'd5, 1'b1, 16'h0000},
    '{16'd1518, 5'h10, 3'd2, 1'b0, 16'h2010}    // R6 wrap, R8 ring full
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic descWr(input int idx, input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    descWrEn = 1; descWrIdx = IDX_W'(idx); descWrSel = sel; descWrData = data;
    @(negedge clk);
    descWrEn = 0;
  endtask

  task automatic poll(input logic [31:0] data);
    @(negedge clk);
    pollWrEn = 1; pollWrData = data;
    @(negedge clk);
    pollWrEn = 0;
  endtask

  task automatic baseWr(input int idx);
    @(negedge clk);
    baseWrEn = 1; baseWrIdx = IDX_W'(idx);
    @(negedge clk);
    baseWrEn = 0;
  endtask

  task automatic readDesc(input int idx);
    descRdIdx = IDX_W'(idx);
    #1;
  endtask

  // drives one frame; returns after the descriptor close has taken effect
  task automatic sendFrame(input int len, input logic [4:0] err, input bit accept,
                           input logic [31:0] bufBase);
    wrSeen = 0; wrBad = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      inValid = 1; inData = 8'(k * 7 + 3); inLast = (k == len - 1);
      inErr = (k == len - 1) ? err : 5'h00;
      #1;
      if (memWrEn !== (accept && k < LIMIT)) wrBad++;
      if (memWrEn === 1'b1) begin
        wrSeen++;
        if (memWrAddr !== bufBase + 32'(k) || memWrData !== 8'(k * 7 + 3)) wrBad++;
      end
    end
    @(negedge clk);
    inValid = 0; inLast = 0; inErr = '0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rxActive", rxActive, 0);
    chk("R1 overrunCnt", overrunCnt, 0);
    chk("R1 ringIdx", ringIdx, 0);
    chk("R1 memWrEn", memWrEn, 0);
    readDesc(5);
    chk("R1 desc status", descRdStatus, 0);
    rstN = 1;

    // R10 base load while disabled
    baseWr(2);
    chk("R10 base load", ringIdx, 2);
    // R11 descriptor setup through the software port
    for (int i = 2; i <= 5; i++) begin
      descWr(i, 2'd0, (i == 5) ? 32'hA000 : 32'h8000);
      descWr(i, 2'd2, 32'h1000 * i);
    end
    readDesc(5);
    chk("R11 status rd", descRdStatus, 16'hA000);
    chk("R11 addr rd", descRdAddr, 32'h5000);
    enable = 1;
    poll(32'h0000_0001);
    chk("R2 bad poll ignored", rxActive, 0);
    poll(32'h0100_0000);
    chk("R2 poll resumes", rxActive, 1);

    cur = 2;
    foreach (VECS[v]) begin
      sendFrame(int'(VECS[v].len), VECS[v].err, 1, 32'h1000 * cur);
      chk("R3 write count", wrSeen, VECS[v].len);
      chk("R3 write addr/data", wrBad, 0);
      readDesc(cur);
      chk("R4 status", descRdStatus, VECS[v].stat);
      chk("R4 length", descRdLen, VECS[v].len);
      chk("R6 ring index", ringIdx, VECS[v].idx);
      chk("R8 active after close", rxActive, VECS[v].act);
      cur = int'(VECS[v].idx);
    end

    // R7 frame while parked is dropped
    sendFrame(64, 5'h00, 0, 32'h2000);
    chk("R7 no writes", wrSeen + wrBad, 0);
    chk("R7 overrun count", overrunCnt, 1);
    readDesc(2);
    chk("R7 desc untouched", descRdStatus, 16'h0000);
    chk("R7 index held", ringIdx, 2);

    // R2 poll with a non-empty current descriptor keeps the engine parked
    poll(32'h0100_0000);
    chk("R2 poll not empty", rxActive, 0);
    descWr(2, 2'd0, 32'h8000);
    poll(32'h0100_0000);
    chk("R2 poll rearm", rxActive, 1);

    // R9 over-length frame
    sendFrame(1525, 5'h00, 1, 32'h2000);
    chk("R9 writes capped", wrSeen, LIMIT);
    chk("R9 write check", wrBad, 0);
    readDesc(2);
    chk("R9 length", descRdLen, LIMIT);
    chk("R9 trunc bit", descRdStatus, 16'h0020);
    chk("R8 next not empty", rxActive, 0);

    // R10 base write ignored while enabled, honoured after disable
    baseWr(6);
    chk("R10 base ignored", ringIdx, 3);
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R10 disable parks", rxActive, 0);
    baseWr(6);
    chk("R10 base reload", ringIdx, 6);

    // R7 active but descriptor reclaimed by software
    descWr(6, 2'd0, 32'h8000);
    enable = 1;
    poll(32'h0100_0000);
    chk("R2 active at slot 6", rxActive, 1);
    descWr(6, 2'd0, 32'h0000);
    sendFrame(80, 5'h00, 0, 32'h0);
    chk("R7 reclaimed drop", overrunCnt, 2);
    chk("R7 parked", rxActive, 0);
    chk("R7 no writes 2", wrSeen + wrBad, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule